// File: doc/BRIEF.md
# A-MPDU Aggregation Limiter

This block decides, one candidate at a time, whether an MPDU queued for a single destination may join the aggregate being built or whether that aggregate has to be closed first. Each candidate arrives with its MCS index and its byte length over a valid/ready handshake. The block keeps a running subframe count and a running byte total, and gives one verdict per candidate one cycle after the handshake. A *join* pulse means the candidate was added to the current aggregate. A *close* pulse means the current aggregate was sealed and the candidate opened the next one.

There are two limit modes, chosen by a mode input. In count mode, a packed word of eight 4-bit fields gives a per-MCS ceiling on the number of subframes, and every spatial-stream multiple of an MCS shares one field. In byte mode, a 17-bit cap bounds the total aggregate size. A start pulse empties the accumulator before a new destination is served. Queueing, padding and delimiter insertion are handled around this block.

Top module: `ampdu_agg_limiter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `agg_count` and `agg_bytes` are 0, and `cand_join` and `agg_close` are low.
- R2: In a cycle with `agg_start` high, `cand_ready` is low and any candidate offered is ignored. In the next cycle `agg_count` and `agg_bytes` are 0 and neither verdict pulse is raised.
- R3: A candidate offered to an empty aggregate (count 0) always joins, whatever its length, cap or limit field. Afterwards the count is 1 and the byte total equals its length.
- R4: In count mode (`mode_bytes` = 0), the ceiling for MCS index m is the field at bits [4k+3:4k] of `count_limits`, where k = m mod 8. MCS 8, 16 and 24 therefore use the same field as MCS 0.
- R5: In count mode, a candidate joins when the count after adding it stays at or below the ceiling. Otherwise `agg_close` pulses, and the count becomes 1 and the byte total becomes the candidate's length.
- R6: A limit field of 0 acts as a ceiling of 1, so every such aggregate carries exactly one subframe.
- R7: In count mode, the first MPDU of an aggregate fixes its MCS. A later candidate with any other MCS index, including one that shares the same limit field, closes the aggregate and opens the next.
- R8: In byte mode (`mode_bytes` = 1), a candidate joins when the byte total plus its length is at or below `byte_cap`, regardless of its MCS. Otherwise it closes the aggregate and opens the next.
- R9: Each accepted handshake yields exactly one of `cand_join` or `agg_close`. That pulse is high for the single cycle after the handshake edge, and both are low in any cycle that follows no handshake.
- R10: When the count has reached its maximum (255 by default), the next candidate closes the aggregate in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_bytes | input | 1 | 0 = per-MCS subframe-count limit, 1 = byte-size cap |
| count_limits | input | 32 | Eight 4-bit subframe ceilings; field k serves MCS indices with index mod 8 = k |
| byte_cap | input | 17 | Maximum aggregate size in bytes (byte mode) |
| agg_start | input | 1 | Pulse that empties the accumulator |
| cand_valid | input | 1 | A candidate MPDU is offered |
| cand_ready | output | 1 | Block can take a candidate this cycle |
| cand_mcs | input | 5 | MCS index of the candidate |
| cand_len | input | 14 | Candidate length in bytes |
| cand_join | output | 1 | Pulse: last candidate joined the current aggregate |
| agg_close | output | 1 | Pulse: aggregate sealed, last candidate opened a new one |
| agg_count | output | 8 | Subframes in the aggregate being built |
| agg_bytes | output | 18 | Bytes in the aggregate being built |

## Verification
The verdict pulses and the updated count and byte total all come from registers loaded on the handshake edge. The bench drives a candidate on a falling edge and checks all four results on the next falling edge, exactly one register stage later. It then holds the handshake idle for one more cycle and checks that both pulses have dropped. The start pulse is checked the same way: its cleared state is read one falling edge after the pulse is driven. `cand_ready` is read during the start cycle itself, because it responds combinationally.

// File: rtl/ampdu_lim_pkg.sv
package ampdu_lim_pkg;
   typedef enum logic {
      LIM_COUNT = 1'b0,
      LIM_BYTES = 1'b1
   } lim_mode_e;
endpackage

// File: rtl/ampdu_lim_field_sel.sv
module ampdu_lim_field_sel #(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int SEL_W      = 3
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0] limit_word,
   input  logic [SEL_W-1:0]              mcs_low,
   output logic [FIELD_W-1:0]            eff_limit
);
   logic [FIELD_W-1:0] fields [NUM_FIELDS];
   logic [FIELD_W-1:0] raw;

   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_unpack
      assign fields[gi] = limit_word[gi*FIELD_W +: FIELD_W];
   end

   if (NUM_FIELDS == 1) begin : g_single
      assign raw = fields[0];
   end else begin : g_multi
      assign raw = fields[mcs_low];
   end

   // zero field behaves as a ceiling of one subframe
   assign eff_limit = (raw == '0) ? FIELD_W'(1) : raw;

   always_comb begin
      assert (eff_limit != '0); // p_eff_nonzero_r6
   end
endmodule

// File: rtl/ampdu_lim_decide.sv
module ampdu_lim_decide
   import ampdu_lim_pkg::*;
#(
   parameter int FIELD_W = 4,
   parameter int CNT_W   = 8,
   parameter int LEN_W   = 14,
   parameter int CAP_W   = 17,
   parameter int ACC_W   = 18,
   parameter int MCS_W   = 5
) (
   input  lim_mode_e          mode,
   input  logic [CNT_W-1:0]   cur_cnt,
   input  logic [ACC_W-1:0]   cur_bytes,
   input  logic [MCS_W-1:0]   cur_mcs,
   input  logic [FIELD_W-1:0] eff_limit,
   input  logic [CAP_W-1:0]   byte_cap,
   input  logic [MCS_W-1:0]   cand_mcs,
   input  logic [LEN_W-1:0]   cand_len,
   output logic               join_ok
);
   localparam int CMP_W = CNT_W + FIELD_W + 1;
   localparam int SUM_W = ACC_W + 1;

   logic             empty;
   logic             cnt_full;
   logic [CMP_W-1:0] next_cnt;
   logic [SUM_W-1:0] next_sum;
   logic             cnt_ok;
   logic             byte_ok;

   assign empty    = (cur_cnt == '0);
   assign cnt_full = &cur_cnt;
   assign next_cnt = CMP_W'(cur_cnt) + CMP_W'(1);
   assign next_sum = SUM_W'(cur_bytes) + SUM_W'(cand_len);
   assign cnt_ok   = (cand_mcs == cur_mcs) && (next_cnt <= CMP_W'(eff_limit));
   assign byte_ok  = (next_sum <= SUM_W'(byte_cap));

   always_comb begin
      if (empty)         join_ok = 1'b1;
      else if (cnt_full) join_ok = 1'b0;
      else if (mode == LIM_BYTES) join_ok = byte_ok;
      else               join_ok = cnt_ok;
   end

   always_comb begin
      assert (!empty || join_ok); // p_empty_joins_r3
   end
endmodule

// File: rtl/ampdu_lim_state.sv
module ampdu_lim_state #(
   parameter int CNT_W = 8,
   parameter int LEN_W = 14,
   parameter int ACC_W = 18,
   parameter int MCS_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  logic             join_ok,
   input  logic [MCS_W-1:0] cand_mcs,
   input  logic [LEN_W-1:0] cand_len,
   output logic [CNT_W-1:0] cnt_q,
   output logic [ACC_W-1:0] bytes_q,
   output logic [MCS_W-1:0] mcs_q,
   output logic             join_q,
   output logic             close_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         bytes_q <= '0;
         mcs_q   <= '0;
         join_q  <= 1'b0;
         close_q <= 1'b0;
      end else begin
         join_q  <= 1'b0;
         close_q <= 1'b0;
         if (start) begin
            cnt_q   <= '0;
            bytes_q <= '0;
         end else if (take) begin
            if (join_ok) begin
               cnt_q   <= cnt_q + CNT_W'(1);
               bytes_q <= bytes_q + ACC_W'(cand_len);
               join_q  <= 1'b1;
               if (cnt_q == '0) mcs_q <= cand_mcs;
            end else begin
               cnt_q   <= CNT_W'(1);
               bytes_q <= ACC_W'(cand_len);
               mcs_q   <= cand_mcs;
               close_q <= 1'b1;
            end
         end
      end
   end

   p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(join_q && close_q));
   p_verdict_needs_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(take) |-> !join_q && !close_q);
   p_join_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      join_q |-> cnt_q == $past(cnt_q) + CNT_W'(1));
   p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      close_q |-> cnt_q == CNT_W'(1) && bytes_q == ACC_W'($past(cand_len)));
   p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> cnt_q == '0 && bytes_q == '0 && !join_q && !close_q);
endmodule

// File: rtl/ampdu_agg_limiter.sv
module ampdu_agg_limiter
   import ampdu_lim_pkg::*;
#(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int MCS_W      = 5,
   parameter int CNT_W      = 8,
   parameter int LEN_W      = 14,
   parameter int CAP_W      = 17
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mode_bytes,
   input  logic [NUM_FIELDS*FIELD_W-1:0] count_limits,
   input  logic [CAP_W-1:0]              byte_cap,
   input  logic                          agg_start,
   input  logic                          cand_valid,
   output logic                          cand_ready,
   input  logic [MCS_W-1:0]              cand_mcs,
   input  logic [LEN_W-1:0]              cand_len,
   output logic                          cand_join,
   output logic                          agg_close,
   output logic [CNT_W-1:0]              agg_count,
   output logic [CAP_W:0]                agg_bytes
);
   localparam int SEL_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;
   localparam int ACC_W = CAP_W + 1;

   if ((NUM_FIELDS & (NUM_FIELDS - 1)) != 0) begin : g_bad_fields
      $error("NUM_FIELDS must be a power of two");
   end
   if (MCS_W < SEL_W) begin : g_bad_mcs
      $error("MCS_W too narrow for the field index");
   end
   if (CNT_W < FIELD_W) begin : g_bad_cnt
      $error("CNT_W must hold the largest field value");
   end
   if (((2 ** FIELD_W) - 1) * ((2 ** LEN_W) - 1) >= (2 ** ACC_W)) begin : g_bad_acc
      $error("byte accumulator too narrow for count mode");
   end

   lim_mode_e          mode;
   logic               take;
   logic               join_ok;
   logic [MCS_W-1:0]   cur_mcs;
   logic [FIELD_W-1:0] eff_limit;

   assign mode       = mode_bytes ? LIM_BYTES : LIM_COUNT;
   assign cand_ready = !agg_start;
   assign take       = cand_valid && cand_ready;

   ampdu_lim_field_sel #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .SEL_W(SEL_W)
   ) u_field_sel (
      .limit_word(count_limits),
      .mcs_low   (cur_mcs[SEL_W-1:0]),
      .eff_limit (eff_limit)
   );

   ampdu_lim_decide #(
      .FIELD_W(FIELD_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
      .CAP_W(CAP_W), .ACC_W(ACC_W), .MCS_W(MCS_W)
   ) u_decide (
      .mode     (mode),
      .cur_cnt  (agg_count),
      .cur_bytes(agg_bytes),
      .cur_mcs  (cur_mcs),
      .eff_limit(eff_limit),
      .byte_cap (byte_cap),
      .cand_mcs (cand_mcs),
      .cand_len (cand_len),
      .join_ok  (join_ok)
   );

   ampdu_lim_state #(
      .CNT_W(CNT_W), .LEN_W(LEN_W), .ACC_W(ACC_W), .MCS_W(MCS_W)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (agg_start),
      .take    (take),
      .join_ok (join_ok),
      .cand_mcs(cand_mcs),
      .cand_len(cand_len),
      .cnt_q   (agg_count),
      .bytes_q (agg_bytes),
      .mcs_q   (cur_mcs),
      .join_q  (cand_join),
      .close_q (agg_close)
   );

   p_ready_in_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      agg_start |-> !cand_ready);
   p_count_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cand_join && !$past(mode_bytes) |-> agg_count <= CNT_W'($past(eff_limit)));
   p_byte_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cand_join && $past(mode_bytes) && agg_count > CNT_W'(1)
      |-> agg_bytes <= ACC_W'($past(byte_cap)));
   p_mcs_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cand_join && !$past(mode_bytes) && agg_count > CNT_W'(1)
      |-> $past(cand_mcs) == cur_mcs);
endmodule

// File: tb/ampdu_agg_limiter_bench.sv
`timescale 1ns/1ps
module ampdu_agg_limiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_bytes = 1'b0;
   logic [31:0] count_limits = '0;
   logic [16:0] byte_cap = '0;
   logic        agg_start = 1'b0;
   logic        cand_valid = 1'b0;
   logic        cand_ready;
   logic [4:0]  cand_mcs = '0;
   logic [13:0] cand_len = '0;
   logic        cand_join;
   logic        agg_close;
   logic [7:0]  agg_count;
   logic [17:0] agg_bytes;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_cnt = 0;
   int m_bytes = 0;
   int m_mcs = 0;

   always #10 clk = ~clk;

   ampdu_agg_limiter u_ampdu_agg_limiter (
      .clk(clk), .rst_n(rst_n), .mode_bytes(mode_bytes),
      .count_limits(count_limits), .byte_cap(byte_cap),
      .agg_start(agg_start), .cand_valid(cand_valid), .cand_ready(cand_ready),
      .cand_mcs(cand_mcs), .cand_len(cand_len), .cand_join(cand_join),
      .agg_close(agg_close), .agg_count(agg_count), .agg_bytes(agg_bytes)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ceiling_for(input int mcs);
      int f;
      f = int'((count_limits >> (4 * (mcs % 8))) & 32'hF);
      return (f == 0) ? 1 : f;
   endfunction

   task automatic do_start(input bit with_cand);
      @(negedge clk);
      agg_start  = 1'b1;
      cand_valid = with_cand;
      cand_mcs   = 5'd9;
      cand_len   = 14'd77;
      #1;
      check("R2", "ready during start", cand_ready, 0);
      @(negedge clk);
      agg_start  = 1'b0;
      cand_valid = 1'b0;
      check("R2", "count after start", agg_count, 0);
      check("R2", "bytes after start", agg_bytes, 0);
      check("R2", "verdict after start", {cand_join, agg_close}, 0);
      m_cnt = 0; m_bytes = 0;
   endtask

   task automatic send(input string req, input int mcs, input int len);
      bit exp_join;
      if (m_cnt == 0) exp_join = 1;
      else if (m_cnt == 255) exp_join = 0;
      else if (mode_bytes) exp_join = (m_bytes + len) <= int'(byte_cap);
      else exp_join = (mcs == m_mcs) && (m_cnt + 1 <= ceiling_for(m_mcs));
      if (exp_join) begin
         if (m_cnt == 0) m_mcs = mcs;
         m_cnt++; m_bytes += len;
      end else begin
         m_cnt = 1; m_bytes = len; m_mcs = mcs;
      end
      @(negedge clk);
      cand_valid = 1'b1;
      cand_mcs   = 5'(mcs);
      cand_len   = 14'(len);
      @(negedge clk);
      cand_valid = 1'b0;
      check(req, "join", cand_join, exp_join);
      check(req, "close", agg_close, !exp_join);
      check(req, "count", agg_count, m_cnt);
      check(req, "bytes", agg_bytes, m_bytes);
      @(negedge clk);
      check("R9", "pulse dropped", {cand_join, agg_close}, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int caps [5] = '{0, 1000, 1500, 4000, 131071};
      int lens [6] = '{1, 500, 999, 1000, 1001, 16383};
      repeat (3) @(negedge clk);
      check("R1", "count in reset", agg_count, 0);
      check("R1", "bytes in reset", agg_bytes, 0);
      check("R1", "verdict in reset", {cand_join, agg_close}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "count after reset", agg_count, 0);
      check("R1", "verdict after reset", {cand_join, agg_close}, 0);

      // count mode sweep: every MCS index against every field value (R4 R5 R6 R3)
      mode_bytes = 1'b0;
      for (int mcs = 0; mcs < 32; mcs++) begin
         for (int lim = 0; lim < 16; lim++) begin
            int eff;
            string tag;
            count_limits = '0;
            for (int f = 0; f < 8; f++)
               count_limits[4*f +: 4] = (f == mcs % 8) ? 4'(lim) : 4'(15 - lim);
            eff = (lim == 0) ? 1 : lim;
            tag = (lim == 0) ? "R6" : ((mcs >= 8) ? "R4" : "R5");
            do_start(mcs == 0);
            for (int i = 0; i <= eff; i++)
               send((i == 0) ? "R3" : tag, mcs, 100 + i);
         end
      end

      // MCS change closes even when sharing a field (R7)
      count_limits = 32'hFFFF_FFFF;
      do_start(0);
      send("R7", 3, 200); send("R7", 3, 201); send("R7", 3, 202);
      send("R7", 11, 300); send("R7", 11, 301); send("R7", 4, 50);

      // start in mid-aggregate clears it (R2)
      send("R2", 4, 60);
      do_start(1);
      send("R2", 4, 70);

      // byte mode sweep, MCS varied to show it is ignored (R8 R3)
      mode_bytes = 1'b1;
      count_limits = '0;
      foreach (caps[c]) begin
         foreach (lens[l]) begin
            byte_cap = 17'(caps[c]);
            do_start(0);
            for (int i = 0; i < 5; i++)
               send((i == 0) ? "R3" : "R8", (i * 7 + l) % 32, lens[l]);
         end
      end

      // count saturation with zero-length candidates (R10)
      byte_cap = 17'd131071;
      do_start(0);
      for (int i = 0; i < 257; i++)
         send((i >= 255) ? "R10" : "R8", i % 32, 0);

      finish_run();
   end
endmodule